// File: doc/BRIEF.md
# Sobel Edge and Direction Classifier

This block takes one complete 3x3 neighbourhood of intensity samples and decides whether its centre sample lies on an edge and, if it does, which of eight compass directions the edge faces. It computes four signed gradients: the vertical axis, the horizontal axis and the two diagonals. Each gradient weights the middle sample of a side by two and needs only adders and a one-bit shift. The strongest gradient sets the direction. Its magnitude, plus one eighth of the magnitude of the gradient at right angles to it, is compared against a small programmable threshold.

A window producer presents the nine samples and a threshold together with a one-cycle valid strobe. A new window may arrive on every clock. Each window gives one result beat, marked by its own valid strobe, a fixed number of cycles later. Forming the window from a pixel stream, buffering lines and using the result further on are left to the surrounding logic.

Top module: `sobel_edge_classifier`

## Requirements
- R1: The window port packs sample t[r][c] (row r = 0 at the top, column c = 0 at the left) at bits [(3r+c)*10 +: 10]. With s(a,b,c) = a + 2b + c, the four gradients are: vertical = s(t00,t01,t02) - s(t20,t21,t22); horizontal = s(t02,t12,t22) - s(t00,t10,t20); rising diagonal = s(t01,t02,t12) - s(t10,t20,t21); falling diagonal = s(t10,t00,t01) - s(t21,t22,t12). They are exact for all 10-bit inputs, up to magnitude 4092.
- R2: The winning gradient has the largest magnitude. On equal magnitudes the order of preference is vertical, horizontal, rising diagonal, falling diagonal.
- R3: The direction code is N=000, NE=001, E=010, SE=011, S=100, SW=101, W=110, NW=111. A winning gradient that is zero or positive reports N, E, NE or NW for the vertical, horizontal, rising and falling axis in that order. A negative one reports the opposite end: S, W, SW or SE.
- R4: An edge is flagged when the winning magnitude plus the perpendicular magnitude divided by eight is greater than or equal to the 7-bit threshold. Equality counts as an edge. The vertical and horizontal axes are perpendicular to each other, and so are the two diagonals.
- R5: When no edge is flagged, the direction output is 000.
- R6: A window captured on a rising edge gives res_valid high for exactly one cycle, from the third rising edge after the capturing edge onward, so the result appears on the fourth edge counting the capture. Windows on consecutive cycles give results on consecutive cycles, in order.
- R7: While res_valid is low, res_edge is 0 and res_dir is 000.
- R8: A low rst_n clears all outputs at once, without a clock. After rst_n rises, windows offered on the first two rising edges are discarded.
- R9: The threshold is sampled together with the window. Later changes on the threshold input do not alter a result already in flight.
- R10: The division by eight truncates toward zero, so a perpendicular magnitude of 14 adds 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| win_valid | input | 1 | Window and threshold are presented this cycle |
| win_pix | input | 90 | Nine 10-bit samples, packed as in R1 |
| win_thresh | input | 7 | Unsigned edge threshold |
| res_valid | output | 1 | Result beat |
| res_edge | output | 1 | Centre sample is an edge |
| res_dir | output | 3 | Edge direction code as in R3 |

## Verification
The hardest situations to reach from the ports are exact ties between gradient magnitudes and the case where truncating the perpendicular term decides the threshold comparison. Neither occurs with ordinary image content. The stimulus uses hand-placed windows with one, two or three lit samples, chosen so that two or three axes give the same magnitude. It also uses a pair of corner samples whose perpendicular magnitude is 14, swept against thresholds one apart. Full-scale rows test the widest gradients. A threshold change right after capture and a reset asserted while a result is in flight cover R9 and R8.

// File: rtl/sobel_pkg.sv
package sobel_pkg;

  localparam int N_AXES = 4;

  typedef enum logic [2:0] {
    DIR_N  = 3'd0,
    DIR_NE = 3'd1,
    DIR_E  = 3'd2,
    DIR_SE = 3'd3,
    DIR_S  = 3'd4,
    DIR_SW = 3'd5,
    DIR_W  = 3'd6,
    DIR_NW = 3'd7
  } dir_e;

  // Axis index: 0 vertical, 1 horizontal, 2 rising diagonal, 3 falling diagonal.
  // Perpendicular partner is index ^ 1; the opposite compass end is code ^ 3'b100.
  function automatic dir_e axis_dir(input logic [1:0] axis, input logic neg);
    logic [2:0] base;
    case (axis)
      2'd0:    base = DIR_N;
      2'd1:    base = DIR_E;
      2'd2:    base = DIR_NE;
      default: base = DIR_NW;
    endcase
    return dir_e'(base ^ {neg, 2'b00});
  endfunction

endpackage

// File: rtl/sobel_deriv.sv
module sobel_deriv #(
  parameter int PIX_W = 10,
  parameter int TH_W  = 7,
  parameter int D_W   = PIX_W + 3
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   in_valid,
  input  logic [9*PIX_W-1:0]                     in_pix,
  input  logic [TH_W-1:0]                        in_thresh,
  output logic                                   out_valid,
  output logic [sobel_pkg::N_AXES-1:0][D_W-1:0]  out_der,
  output logic [TH_W-1:0]                        out_thresh
);
  import sobel_pkg::*;

  logic [8:0][PIX_W-1:0]       px;
  logic [N_AXES-1:0][D_W-1:0]  der_nxt;

  assign px = in_pix;

  function automatic logic [D_W-1:0] side(input logic [PIX_W-1:0] a, b, c);
    return D_W'(a) + (D_W'(b) << 1) + D_W'(c);
  endfunction

  always_comb begin
    der_nxt[0] = side(px[0], px[1], px[2]) - side(px[6], px[7], px[8]);
    der_nxt[1] = side(px[2], px[5], px[8]) - side(px[0], px[3], px[6]);
    der_nxt[2] = side(px[1], px[2], px[5]) - side(px[3], px[6], px[7]);
    der_nxt[3] = side(px[3], px[0], px[1]) - side(px[7], px[8], px[5]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_der    <= '0;
      out_thresh <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_der    <= der_nxt;
        out_thresh <= in_thresh;
      end
    end
  end

endmodule

// File: rtl/sobel_mag.sv
module sobel_mag #(
  parameter int TH_W = 7,
  parameter int D_W  = 13,
  parameter int M_W  = D_W - 1
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   in_valid,
  input  logic [sobel_pkg::N_AXES-1:0][D_W-1:0]  in_der,
  input  logic [TH_W-1:0]                        in_thresh,
  output logic                                   out_valid,
  output logic [sobel_pkg::N_AXES-1:0][M_W-1:0]  out_mag,
  output logic [sobel_pkg::N_AXES-1:0]           out_neg,
  output logic [TH_W-1:0]                        out_thresh
);
  import sobel_pkg::*;

  logic [N_AXES-1:0][M_W-1:0] mag_nxt;
  logic [N_AXES-1:0]          neg_nxt;

  for (genvar g = 0; g < N_AXES; g++) begin : g_axis
    logic [D_W-1:0] flipped;
    assign neg_nxt[g] = in_der[g][D_W-1];
    assign flipped    = D_W'(0) - in_der[g];
    assign mag_nxt[g] = neg_nxt[g] ? flipped[M_W-1:0] : in_der[g][M_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_mag    <= '0;
      out_neg    <= '0;
      out_thresh <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_mag    <= mag_nxt;
        out_neg    <= neg_nxt;
        out_thresh <= in_thresh;
      end
    end
  end

endmodule

// File: rtl/sobel_select.sv
module sobel_select #(
  parameter int TH_W = 7,
  parameter int M_W  = 12
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   in_valid,
  input  logic [sobel_pkg::N_AXES-1:0][M_W-1:0]  in_mag,
  input  logic [sobel_pkg::N_AXES-1:0]           in_neg,
  input  logic [TH_W-1:0]                        in_thresh,
  output logic                                   out_valid,
  output logic [M_W-1:0]                         out_max,
  output logic [M_W-1:0]                         out_perp,
  output sobel_pkg::dir_e                        out_dir,
  output logic [TH_W-1:0]                        out_thresh
);
  import sobel_pkg::*;

  logic [1:0]     best;
  logic [M_W-1:0] max_nxt;
  logic [M_W-1:0] perp_nxt;
  dir_e           dir_nxt;

  // Strict comparison keeps the earlier axis on a tie.
  always_comb begin
    best = 2'd0;
    for (int i = 1; i < N_AXES; i++) begin
      if (in_mag[i] > in_mag[best]) best = 2'(i);
    end
    max_nxt  = in_mag[best];
    perp_nxt = in_mag[best ^ 2'b01];
    dir_nxt  = axis_dir(best, in_neg[best]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_max    <= '0;
      out_perp   <= '0;
      out_dir    <= DIR_N;
      out_thresh <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_max    <= max_nxt;
        out_perp   <= perp_nxt;
        out_dir    <= dir_nxt;
        out_thresh <= in_thresh;
      end
    end
  end

endmodule

// File: rtl/sobel_decide.sv
module sobel_decide #(
  parameter int TH_W = 7,
  parameter int M_W  = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [M_W-1:0]   in_max,
  input  logic [M_W-1:0]   in_perp,
  input  sobel_pkg::dir_e  in_dir,
  input  logic [TH_W-1:0]  in_thresh,
  output logic             out_valid,
  output logic             out_edge,
  output sobel_pkg::dir_e  out_dir
);
  import sobel_pkg::*;

  localparam int S_W = M_W + 1;
  localparam int C_W = (S_W > TH_W) ? S_W : TH_W;

  logic [C_W-1:0] score;
  logic           hit;
  logic           edge_nxt;
  dir_e           dir_nxt;

  always_comb begin
    score    = C_W'(in_max) + C_W'(in_perp >> 3);
    hit      = score >= C_W'(in_thresh);
    edge_nxt = in_valid && hit;
    dir_nxt  = edge_nxt ? in_dir : DIR_N;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_edge  <= 1'b0;
      out_dir   <= DIR_N;
    end else begin
      out_valid <= in_valid;
      out_edge  <= edge_nxt;
      out_dir   <= dir_nxt;
    end
  end

endmodule

// File: rtl/sobel_edge_classifier.sv
module sobel_edge_classifier #(
  parameter int PIX_W = 10,
  parameter int TH_W  = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               win_valid,
  input  logic [9*PIX_W-1:0] win_pix,
  input  logic [TH_W-1:0]    win_thresh,
  output logic               res_valid,
  output logic               res_edge,
  output logic [2:0]         res_dir
);
  import sobel_pkg::*;

  localparam int D_W = PIX_W + 3;
  localparam int M_W = PIX_W + 2;

  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic                        v1, v2, v3;
  logic [N_AXES-1:0][D_W-1:0]  der;
  logic [N_AXES-1:0][M_W-1:0]  mag;
  logic [N_AXES-1:0]           neg;
  logic [TH_W-1:0]             th1, th2, th3;
  logic [M_W-1:0]              emax, eperp;
  dir_e                        dmax, dout;

  sobel_deriv #(.PIX_W(PIX_W), .TH_W(TH_W), .D_W(D_W)) u_deriv (
    .clk(clk), .rst_n(rst_sync_n), .in_valid(win_valid), .in_pix(win_pix),
    .in_thresh(win_thresh), .out_valid(v1), .out_der(der), .out_thresh(th1)
  );

  sobel_mag #(.TH_W(TH_W), .D_W(D_W), .M_W(M_W)) u_mag (
    .clk(clk), .rst_n(rst_sync_n), .in_valid(v1), .in_der(der), .in_thresh(th1),
    .out_valid(v2), .out_mag(mag), .out_neg(neg), .out_thresh(th2)
  );

  sobel_select #(.TH_W(TH_W), .M_W(M_W)) u_select (
    .clk(clk), .rst_n(rst_sync_n), .in_valid(v2), .in_mag(mag), .in_neg(neg),
    .in_thresh(th2), .out_valid(v3), .out_max(emax), .out_perp(eperp),
    .out_dir(dmax), .out_thresh(th3)
  );

  sobel_decide #(.TH_W(TH_W), .M_W(M_W)) u_decide (
    .clk(clk), .rst_n(rst_sync_n), .in_valid(v3), .in_max(emax), .in_perp(eperp),
    .in_dir(dmax), .in_thresh(th3), .out_valid(res_valid), .out_edge(res_edge),
    .out_dir(dout)
  );

  assign res_dir = dout;

endmodule

// File: rtl/sobel_edge_chk.sv
module sobel_edge_chk #(
  parameter int TH_W = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic            win_valid,
  input logic [TH_W-1:0] win_thresh,
  input logic            res_valid,
  input logic            res_edge,
  input logic [2:0]      res_dir
);

  logic [3:0] vhist;
  logic [3:0] zhist;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vhist <= '0;
      zhist <= '0;
    end else begin
      vhist <= {vhist[2:0], win_valid};
      zhist <= {zhist[2:0], win_valid && (win_thresh == '0)};
    end
  end

  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) res_valid == vhist[3]); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !res_valid |-> (!res_edge && res_dir == 3'd0)); // R7
  AST_NOEDGE_DIR: assert property (@(posedge clk) disable iff (!rst_n) (res_valid && !res_edge) |-> res_dir == 3'd0); // R5
  AST_ZERO_THRESH: assert property (@(posedge clk) disable iff (!rst_n) (res_valid && zhist[3]) |-> res_edge); // R4

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (!res_valid && !res_edge && res_dir == 3'd0); // R8
    end
  end

endmodule

bind sobel_edge_classifier sobel_edge_chk #(.TH_W(TH_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .win_valid(win_valid), .win_thresh(win_thresh),
  .res_valid(res_valid), .res_edge(res_edge), .res_dir(res_dir)
);

// File: tb/sim_sobel_edge_classifier.sv
`timescale 1ns/1ps
module sim_sobel_edge_classifier;

  localparam int NV = 20;

  logic        clk;
  logic        rst_n;
  logic        win_valid;
  logic [89:0] win_pix;
  logic [6:0]  win_thresh;
  logic        res_valid;
  logic        res_edge;
  logic [2:0]  res_dir;

  int checks;
  int failures;

  sobel_edge_classifier u0 (
    .clk(clk), .rst_n(rst_n), .win_valid(win_valid), .win_pix(win_pix),
    .win_thresh(win_thresh), .res_valid(res_valid), .res_edge(res_edge),
    .res_dir(res_dir)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // vector: {pixels[89:0], thresh[6:0], edge, dir[2:0]}; pixel t[r][c] at slot 3r+c
  function automatic logic [100:0] mk(input int t00, t01, t02, t10, t11, t12,
                                      t20, t21, t22, th, e, d);
    logic [8:0][9:0] p;
    p[0] = 10'(t00); p[1] = 10'(t01); p[2] = 10'(t02);
    p[3] = 10'(t10); p[4] = 10'(t11); p[5] = 10'(t12);
    p[6] = 10'(t20); p[7] = 10'(t21); p[8] = 10'(t22);
    return {p, 7'(th), 1'(e), 3'(d)};
  endfunction

  localparam logic [100:0] VEC [NV] = '{
    mk(0,0,0, 0,0,0, 0,0,0, 0, 1,0),                 // R4 equality at zero, R3 N
    mk(0,0,0, 0,0,0, 0,0,0, 1, 0,0),                 // R5
    mk(100,100,100, 0,0,0, 0,0,0, 127, 1,0),         // R3 N
    mk(0,0,0, 0,0,0, 100,100,100, 127, 1,4),         // R3 S
    mk(0,0,100, 0,0,100, 0,0,100, 127, 1,2),         // R3 E
    mk(100,0,0, 100,0,0, 100,0,0, 127, 1,6),         // R3 W
    mk(0,100,100, 0,0,100, 0,0,0, 127, 1,1),         // R1 rising diagonal, NE
    mk(0,0,0, 100,0,0, 100,100,0, 127, 1,5),         // R1 SW
    mk(100,100,0, 100,0,0, 0,0,0, 127, 1,7),         // R1 falling diagonal, NW
    mk(0,0,0, 0,0,100, 0,100,100, 127, 1,3),         // R1 SE
    mk(0,100,0, 0,0,100, 0,0,0, 127, 1,0),           // R2 three-way tie -> vertical
    mk(0,0,0, 0,0,100, 0,0,100, 127, 1,2),           // R2 horizontal beats falling diag
    mk(50,0,7, 0,0,0, 0,0,0, 101, 1,7),              // R4 100+1 >= 101
    mk(50,0,7, 0,0,0, 0,0,0, 102, 0,0),              // R10 floor(14/8)=1, R5
    mk(60,0,56, 0,0,0, 0,0,0, 127, 1,7),             // R4 120+14 >= 127 only via perp
    mk(1023,1023,1023, 0,0,0, 0,0,0, 127, 1,0),      // R1 full scale
    mk(0,0,0, 0,0,0, 1023,1023,1023, 127, 1,4),      // R1 full scale negative
    mk(700,700,700, 700,700,700, 700,700,700, 1, 0,0), // R5 flat field
    mk(0,0,10, 0,0,10, 0,0,10, 40, 1,2),             // R4 40 >= 40
    mk(0,0,10, 0,0,10, 0,0,10, 41, 0,0)              // R5 dir cleared
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put(input logic [100:0] v, input logic vld);
    win_pix    = v[100:11];
    win_thresh = v[10:4];
    win_valid  = vld;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    checks = 0;
    failures = 0;
    rst_n = 1'b0;
    put('0, 1'b0);
    repeat (3) @(negedge clk);
    chk("R8 reset valid", int'(res_valid), 0);
    chk("R8 reset edge", int'(res_edge), 0);
    chk("R8 reset dir", int'(res_dir), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Stream all vectors back to back; result of vector i is read 4 negedges later.
    for (int i = 0; i < NV + 4; i++) begin
      @(negedge clk);
      if (i >= 4) begin
        chk($sformatf("R6 valid vec%0d", i - 4), int'(res_valid), 1);
        chk($sformatf("R4 edge vec%0d", i - 4), int'(res_edge), int'(VEC[i-4][3]));
        chk($sformatf("R3 dir vec%0d", i - 4), int'(res_dir), int'(VEC[i-4][2:0]));
      end
      if (i < NV) put(VEC[i], 1'b1);
      else        put('0, 1'b0);
    end

    @(negedge clk);
    chk("R7 idle valid", int'(res_valid), 0);
    chk("R7 idle edge", int'(res_edge), 0);
    chk("R7 idle dir", int'(res_dir), 0);

    // Single window: exact latency and threshold captured with the window.
    put(VEC[12], 1'b1);
    @(negedge clk);
    put(mk(0,0,0, 0,0,0, 0,0,0, 127, 0,0), 1'b0);
    chk("R6 early c1", int'(res_valid), 0);
    @(negedge clk);
    chk("R6 early c2", int'(res_valid), 0);
    @(negedge clk);
    chk("R6 early c3", int'(res_valid), 0);
    @(negedge clk);
    chk("R6 on time", int'(res_valid), 1);
    chk("R9 captured threshold", int'(res_edge), 1);
    chk("R9 dir", int'(res_dir), 7);

    // Asynchronous reset while the result is shown.
    #2 rst_n = 1'b0;
    #1;
    chk("R8 async valid", int'(res_valid), 0);
    chk("R8 async edge", int'(res_edge), 0);
    chk("R8 async dir", int'(res_dir), 0);

    // Windows in the first two edges after release are discarded.
    @(negedge clk);
    rst_n = 1'b1;
    put(VEC[0], 1'b1);
    repeat (2) @(negedge clk);
    put('0, 1'b0);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk($sformatf("R8 discard c%0d", k), int'(res_valid), 0);
    end

    // Pipeline is live afterwards.
    put(VEC[3], 1'b1);
    @(negedge clk);
    put('0, 1'b0);
    repeat (3) @(negedge clk);
    chk("R6 after reset valid", int'(res_valid), 1);
    chk("R3 after reset dir", int'(res_dir), 4);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule